// File: doc/BRIEF.md
# Serial-Output Four-Point Butterfly

This block takes one group of four complex fixed-point samples and computes their four-point discrete Fourier transform. It uses only additions, subtractions and a rotation by a quarter turn, so it needs no general multiplier. It does not present all four results at once. It sends them out one per clock, on a single complex output bus, and tags each result with its frequency index. A downstream stage that handles one sample per cycle, such as a twiddle multiplier, can then connect to it directly with no parallel-to-serial stage in between.

An input group is presented on two packed buses, one for real parts and one for imaginary parts, qualified by a valid strobe. It is taken on a clock edge where both the strobe and the ready output are high. On that edge the block registers the two first-level sums and the two first-level differences. It then builds the four results from those registered values in the order 0, 1, 2, 3. The ready output rises again in the cycle that produces the last result, so a continuous supply of groups gives a gap-free output stream with one new group every four cycles. Each output is two bits wider than each input, which holds the growth through both adder levels.

Top module: `quad_dft_serial`

## Requirements
- R1: While reset is asserted, and right after it is released, out_valid is 0 and in_ready is 1.
- R2: The result tagged index 0 equals (x0 + x2) + (x1 + x3), separately for the real and imaginary parts. Sample k sits in bits [k*IN_W +: IN_W] of each input bus and is two's complement.
- R3: The result tagged index 2 equals (x0 + x2) − (x1 + x3).
- R4: With b = x0 − x2 and d = x1 − x3, the result tagged index 1 is b − j·d: real part b.re + d.im, imaginary part b.im − d.re.
- R5: The result tagged index 3 is b + j·d: real part b.re − d.im, imaginary part b.im + d.re.
- R6: A group taken on clock edge n produces its results at indices 0, 1, 2, 3, with out_valid high, on edges n+1, n+2, n+3 and n+4 in turn, one result per edge.
- R7: After a group is taken on edge n, in_ready is low after edges n, n+1 and n+2 and high again after edge n+3. An in_valid that arrives while in_ready is low has no effect on the outputs.
- R8: If a new group is offered as soon as in_ready is high, the groups are taken every four cycles and out_valid stays high with no gap. No output appears without a taken group.
- R9: Each output is IN_W+2 bits wide, and every input value, including all-minimum and all-maximum groups, gives the exact result with no wrap-around.
- R10: The input buses are sampled only on the edge that takes the group. Later changes to them do not alter that group's results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | An input group is present |
| in_ready | output | 1 | The block can take a group on this edge |
| in_re | input | 4*IN_W | Real parts of samples 0..3, sample k in bits [k*IN_W +: IN_W] |
| in_im | input | 4*IN_W | Imaginary parts, packed the same way |
| out_valid | output | 1 | A transform result is on the output bus |
| out_idx | output | 2 | Frequency index of the current result |
| out_re | output | IN_W+2 | Real part of the result |
| out_im | output | IN_W+2 | Imaginary part of the result |

## Verification
The bench counts rising edges and notes the edge n on which each group is taken. It then expects result k exactly after edge n+1+k, and expects in_ready to stay low after edges n through n+2. All inputs are driven just after a falling edge, and all outputs are compared at the falling edge. Each comparison therefore looks at a stable value that is due in that exact cycle. A result that arrives early, late or out of order fails its cycle check, and a result that never arrives is reported once its due edge has passed.

// File: rtl/qdft_pkg.sv
package qdft_pkg;

    localparam int POINTS = 4;
    localparam int IDX_W  = $clog2(POINTS);

    typedef logic [IDX_W-1:0] idx_t;

    typedef enum logic [IDX_W-1:0] {
        PH_BIN0 = 2'd0,
        PH_BIN1 = 2'd1,
        PH_BIN2 = 2'd2,
        PH_BIN3 = 2'd3
    } phase_e;

    localparam idx_t LAST_IDX = idx_t'(POINTS - 1);

endpackage

// File: rtl/qdft_seq.sv
module qdft_seq
    import qdft_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    output logic in_ready,
    output logic load,
    output logic fire,
    output idx_t sel
);

    typedef struct packed {
        logic busy;
        idx_t cnt;
    } seq_t;

    seq_t st_d, st_q;
    logic last;

    // the last output of a group is produced in the same cycle a new group may land
    assign last     = st_q.busy && (st_q.cnt == LAST_IDX);
    assign in_ready = !st_q.busy || last;
    assign load     = in_valid && in_ready;
    assign fire     = st_q.busy;
    assign sel      = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.busy = 1'b1;
            st_d.cnt  = '0;
        end else if (last) begin
            st_d.busy = 1'b0;
            st_d.cnt  = '0;
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt + idx_t'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/qdft_presum.sv
module qdft_presum
    import qdft_pkg::*;
#(
    parameter int W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [POINTS*W-1:0]   in_re,
    input  logic [POINTS*W-1:0]   in_im,
    output logic [W:0]            a_re,
    output logic [W:0]            a_im,
    output logic [W:0]            b_re,
    output logic [W:0]            b_im,
    output logic [W:0]            c_re,
    output logic [W:0]            c_im,
    output logic [W:0]            d_re,
    output logic [W:0]            d_im
);

    localparam int SW = W + 1;

    typedef struct packed {
        logic [SW-1:0] ar;
        logic [SW-1:0] ai;
        logic [SW-1:0] br;
        logic [SW-1:0] bi;
        logic [SW-1:0] cr;
        logic [SW-1:0] ci;
        logic [SW-1:0] dr;
        logic [SW-1:0] di;
    } sums_t;

    logic signed [SW-1:0] xr [POINTS];
    logic signed [SW-1:0] xi [POINTS];

    for (genvar k = 0; k < POINTS; k++) begin : g_lane
        assign xr[k] = SW'($signed(in_re[k*W +: W]));
        assign xi[k] = SW'($signed(in_im[k*W +: W]));
    end

    sums_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.ar = xr[0] + xr[2];
            st_d.ai = xi[0] + xi[2];
            st_d.br = xr[0] - xr[2];
            st_d.bi = xi[0] - xi[2];
            st_d.cr = xr[1] + xr[3];
            st_d.ci = xi[1] + xi[3];
            st_d.dr = xr[1] - xr[3];
            st_d.di = xi[1] - xi[3];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_re = st_q.ar;
    assign a_im = st_q.ai;
    assign b_re = st_q.br;
    assign b_im = st_q.bi;
    assign c_re = st_q.cr;
    assign c_im = st_q.ci;
    assign d_re = st_q.dr;
    assign d_im = st_q.di;

endmodule

// File: rtl/qdft_combine.sv
module qdft_combine
    import qdft_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fire,
    input  idx_t         sel,
    input  logic [W:0]   a_re,
    input  logic [W:0]   a_im,
    input  logic [W:0]   b_re,
    input  logic [W:0]   b_im,
    input  logic [W:0]   c_re,
    input  logic [W:0]   c_im,
    input  logic [W:0]   d_re,
    input  logic [W:0]   d_im,
    output logic         out_valid,
    output idx_t         out_idx,
    output logic [W+1:0] out_re,
    output logic [W+1:0] out_im
);

    localparam int OW = W + 2;

    typedef struct packed {
        logic          valid;
        idx_t          idx;
        logic [OW-1:0] re;
        logic [OW-1:0] im;
    } res_t;

    logic signed [OW-1:0] ar, ai, br, bi, cr, ci, dr, di;
    logic signed [OW-1:0] sum_re, sum_im;

    assign ar = OW'($signed(a_re));
    assign ai = OW'($signed(a_im));
    assign br = OW'($signed(b_re));
    assign bi = OW'($signed(b_im));
    assign cr = OW'($signed(c_re));
    assign ci = OW'($signed(c_im));
    assign dr = OW'($signed(d_re));
    assign di = OW'($signed(d_im));

    // second adder level; a quarter-turn rotation is a swap plus one negation
    always_comb begin
        unique case (phase_e'(sel))
            PH_BIN0: begin
                sum_re = ar + cr;
                sum_im = ai + ci;
            end
            PH_BIN1: begin
                sum_re = br + di;
                sum_im = bi - dr;
            end
            PH_BIN2: begin
                sum_re = ar - cr;
                sum_im = ai - ci;
            end
            PH_BIN3: begin
                sum_re = br - di;
                sum_im = bi + dr;
            end
            default: begin
                sum_re = '0;
                sum_im = '0;
            end
        endcase
    end

    res_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = fire;
        if (fire) begin
            st_d.idx = sel;
            st_d.re  = sum_re;
            st_d.im  = sum_im;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_idx   = st_q.idx;
    assign out_re    = st_q.re;
    assign out_im    = st_q.im;

endmodule

// File: rtl/quad_dft_serial.sv
module quad_dft_serial
    import qdft_pkg::*;
#(
    parameter int IN_W = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [POINTS*IN_W-1:0] in_re,
    input  logic [POINTS*IN_W-1:0] in_im,
    output logic                   out_valid,
    output logic [IDX_W-1:0]       out_idx,
    output logic [IN_W+1:0]        out_re,
    output logic [IN_W+1:0]        out_im
);

    localparam int SW = IN_W + 1;

    logic          load;
    logic          fire;
    idx_t          sel;
    logic [SW-1:0] a_re, a_im, b_re, b_im, c_re, c_im, d_re, d_im;

    qdft_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_ready (in_ready),
        .load     (load),
        .fire     (fire),
        .sel      (sel)
    );

    qdft_presum #(.W(IN_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .in_re (in_re),
        .in_im (in_im),
        .a_re  (a_re),
        .a_im  (a_im),
        .b_re  (b_re),
        .b_im  (b_im),
        .c_re  (c_re),
        .c_im  (c_im),
        .d_re  (d_re),
        .d_im  (d_im)
    );

    qdft_combine #(.W(IN_W)) u_cmb (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .sel       (sel),
        .a_re      (a_re),
        .a_im      (a_im),
        .b_re      (b_re),
        .b_im      (b_im),
        .c_re      (c_re),
        .c_im      (c_im),
        .d_re      (d_re),
        .d_im      (d_im),
        .out_valid (out_valid),
        .out_idx   (out_idx),
        .out_re    (out_re),
        .out_im    (out_im)
    );

endmodule

// File: rtl/qdft_props.sv
module qdft_props
    import qdft_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic       in_ready,
    input logic       out_valid,
    input logic [1:0] out_idx
);

    // R6: within a group the index advances by one on every edge
    a_r6_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_idx != LAST_IDX) |=> (out_valid && out_idx == $past(out_idx) + 2'd1));

    // R6: a taken group yields its index-0 result two edges later
    a_r6_first_due: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> ##1 (out_valid && out_idx == 2'd0));

    // R7: no new group while indices 0 or 1 are on the output
    a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (out_idx == 2'd0 || out_idx == 2'd1)) |-> !in_ready);

    // R7: ready reopens while index 2 is on the output
    a_r7_reopen: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_idx == 2'd2) |-> in_ready);

    // R8: continuous supply keeps the output stream gap-free
    a_r8_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_idx == 2'd2 && in_valid) |=> ##1 (out_valid && out_idx == 2'd0));

endmodule

bind quad_dft_serial qdft_props u_props (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_idx   (out_idx)
);

// File: tb/sim_quad_dft_serial.sv
`timescale 1ns/1ps
module sim_quad_dft_serial;

    localparam int IW = 4;
    localparam int OW = IW + 2;
    localparam int QD = 8192;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [4*IW-1:0] in_re = '0;
    logic [4*IW-1:0] in_im = '0;
    logic            in_ready;
    logic            out_valid;
    logic [1:0]      out_idx;
    logic [OW-1:0]   out_re;
    logic [OW-1:0]   out_im;

    quad_dft_serial #(.IN_W(IW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_re     (in_re),
        .in_im     (in_im),
        .out_valid (out_valid),
        .out_idx   (out_idx),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    always #10 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int failures = 0;
    int exp_re [QD];
    int exp_im [QD];
    int exp_ix [QD];
    int exp_due[QD];
    int head = 0;
    int tail = 0;
    int last_acc = -100;
    int seed = 7;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 16);
    endfunction

    task automatic report();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // output and handshake monitor, sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(in_ready == (cyc >= last_acc + 3), "R7", "in_ready",
                int'(in_ready), int'(cyc >= last_acc + 3));
            if (out_valid) begin
                if (head == tail) begin
                    chk(1'b0, "R8", "output without taken group", 1, 0);
                end else begin
                    string req;
                    case (exp_ix[head])
                        0: req = "R2";
                        1: req = "R4";
                        2: req = "R3";
                        default: req = "R5";
                    endcase
                    chk(int'(out_idx) == exp_ix[head], "R6", "index", int'(out_idx), exp_ix[head]);
                    chk(cyc == exp_due[head], "R6", "due edge", cyc, exp_due[head]);
                    chk(int'($signed(out_re)) == exp_re[head], req, "real", int'($signed(out_re)), exp_re[head]);
                    chk(int'($signed(out_im)) == exp_im[head], req, "imag", int'($signed(out_im)), exp_im[head]);
                    head++;
                end
            end else if (head != tail && cyc >= exp_due[head]) begin
                chk(1'b0, "R8", "missing output at edge", cyc, exp_due[head]);
                head++;
            end
        end
    end

    // offer a group; hold it until taken, then record the expected results
    task automatic send(input int r[4], input int i[4]);
        int xr[4];
        int xi[4];
        int acc;
        for (int k = 0; k < 4; k++) begin
            in_re[k*IW +: IW] = r[k][IW-1:0];
            in_im[k*IW +: IW] = i[k][IW-1:0];
        end
        in_valid = 1'b1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        acc = cyc + 1;
        for (int k = 0; k < 4; k++) begin
            xr[k] = int'($signed(in_re[k*IW +: IW]));
            xi[k] = int'($signed(in_im[k*IW +: IW]));
        end
        // R2 R3 R4 R5 expected values
        exp_re[tail] = (xr[0] + xr[2]) + (xr[1] + xr[3]);
        exp_im[tail] = (xi[0] + xi[2]) + (xi[1] + xi[3]);
        exp_re[tail+1] = (xr[0] - xr[2]) + (xi[1] - xi[3]);
        exp_im[tail+1] = (xi[0] - xi[2]) - (xr[1] - xr[3]);
        exp_re[tail+2] = (xr[0] + xr[2]) - (xr[1] + xr[3]);
        exp_im[tail+2] = (xi[0] + xi[2]) - (xi[1] + xi[3]);
        exp_re[tail+3] = (xr[0] - xr[2]) - (xi[1] - xi[3]);
        exp_im[tail+3] = (xi[0] - xi[2]) + (xr[1] - xr[3]);
        for (int k = 0; k < 4; k++) begin
            exp_ix[tail+k]  = k;
            exp_due[tail+k] = acc + 1 + k;
        end
        tail += 4;
        last_acc = acc;
        @(negedge clk);
        #1;
    endtask

    // R10: idle with scrambled data on the buses
    task automatic idle(input int n);
        in_valid = 1'b0;
        for (int c = 0; c < n; c++) begin
            in_re = 16'(rnd());
            in_im = 16'(rnd());
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        #(20 * 150000);
        chk(1'b0, "R6", "watchdog expired", cyc, 0);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        #1;

        // isolated groups, scrambled buses in between (R10)
        send('{1, 2, 3, 4}, '{0, 0, 0, 0});
        idle(6);
        send('{0, 1, 0, 0}, '{0, 0, 0, 0});
        idle(6);
        send('{0, 0, 0, 0}, '{0, 1, 0, -1});
        idle(6);
        send('{-3, 5, 2, -7}, '{4, -1, -6, 3});
        idle(6);

        // R9 extremes
        send('{7, 7, 7, 7}, '{7, 7, 7, 7});
        send('{-8, -8, -8, -8}, '{-8, -8, -8, -8});
        send('{7, -8, -8, 7}, '{-8, 7, 7, -8});
        send('{7, -8, 7, -8}, '{-8, 7, -8, 7});
        send('{-8, 7, 7, -8}, '{7, 7, -8, -8});
        idle(6);

        // R8 back-to-back stream with random groups
        for (int g = 0; g < 300; g++) begin
            send('{rnd(), rnd(), rnd(), rnd()}, '{rnd(), rnd(), rnd(), rnd()});
        end
        idle(5);

        // sweep of two lanes over every value, other lanes derived
        for (int a = -8; a < 8; a++) begin
            for (int b = -8; b < 8; b++) begin
                send('{a, b, -a, 7 - b}, '{b, -a, a + b, a - b});
            end
        end

        // R7: in_valid held high during drain while a different group waits
        send('{2, -2, 5, 1}, '{-4, 3, 0, 6});
        send('{-1, -1, -1, -1}, '{1, 1, 1, 1});
        idle(8);

        chk(head == tail, "R6", "results outstanding", tail - head, 0);
        report();
    end

endmodule